// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Selective Status Update

This block is the data path of a small 8-bit processor core. Each cycle it takes a destination operand, a second operand (a register value or an immediate, chosen outside the block), the current status flags and a 4-bit operation code. It produces the result byte, the next status flags and a mask that marks which flags the operation changed.

The status word has six bits: carry, zero, negative, two's-complement overflow, sign and half-carry. Each operation class changes only its own set of these bits. Any flag outside that set is copied unchanged from the incoming status. The result, flags and mask are registered, so they appear one clock after the inputs. The surrounding core can therefore write the flag output straight back into its status register.

Operation codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 two's complement, 9 increment, 10 decrement, 11 test, 12 clear, 13 set all ones. Codes 14 and 15 are reserved.

Top module: `alu8_core`

## Requirements
- R1: Codes 0 and 1 give a+b (plus flags_in[0] for code 1). Carry is the carry out of bit 7, half-carry is the carry out of bit 3, and V is signed overflow. The mask is 0x3F, so all six flags update.
- R2: Codes 2 and 3 give a−b (minus flags_in[0] for code 3). Carry is the borrow out of bit 7, half-carry is the borrow out of bit 3, and V is signed overflow. The mask is 0x3F.
- R3: For code 3, Z is 1 only when the result is zero and the incoming Z (flags_in[1]) is 1. A nonzero result always clears Z.
- R4: Codes 4, 5 and 6 give a&b, a|b and a^b. They clear V, update only S, V, N and Z (mask 0x1E), and pass carry and half-carry through from flags_in.
- R5: Code 7 gives ~a. It sets carry to 1, clears V and updates Z, C, N, V and S (mask 0x1F).
- R6: Code 8 gives 0−a. Carry is 1 when the result is nonzero, V is 1 only when the result is 0x80, half-carry is bit 3 of a OR bit 3 of the result, and the mask is 0x3F.
- R7: Codes 9 and 10 give a+1 and a−1 with mask 0x1E. V is 1 only when increment starts from 0x7F or decrement starts from 0x80.
- R8: Code 11 gives a (a AND a) and code 12 gives 0 (a XOR a). Both clear V and use mask 0x1E. Code 12 therefore yields Z=1 and N=0.
- R9: Code 13 gives 0xFF with mask 0 and passes all flags through unchanged.
- R10: The flag bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. N is bit 7 of the result, and S is N XOR V whenever S is in the mask. Every flag outside the mask equals its flags_in bit.
- R11: Outputs appear one clock after the inputs. A synchronous reset clears the result, flags and mask. Reserved codes give result 0 and mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| opd_a | input | 8 | Destination operand |
| opd_b | input | 8 | Second operand or immediate |
| flags_in | input | 6 | Current status flags |
| res_q | output | 8 | Registered result |
| flags_q | output | 6 | Registered next status flags |
| upd_q | output | 6 | Registered mask of flags changed |

## Verification
The arithmetic codes are tried at the byte boundaries, where they separate the flags from each other:
- 0x7F+1 and 0x80−1 give overflow without carry.
- 0xFF+1 gives carry without overflow.
- 0x0F+1 gives a half-carry only.
- Incoming carry set or clear separates the plain codes from the with-carry codes.

Subtract with carry is run with incoming Z both set and clear, so the sticky zero rule is tested against the plain zero rule. The logic codes run with carry and half-carry preset to 1, so any leak into those flags shows up. A long run of mixed codes with random operands and random incoming flags compares every result against an integer reference model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_COM = 4'd7,
    OP_NEG = 4'd8, OP_INC = 4'd9, OP_DEC = 4'd10, OP_TST = 4'd11,
    OP_CLR = 4'd12, OP_SER = 4'd13
  } alu_op_e;

  localparam int NFLAG = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8,
  parameter int HB = 3
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          hc,
  output logic          ovf
);
  logic [DW-1:0] yy;
  logic          ci;
  logic          co;
  logic [HB+1:0] lo;

  always_comb begin
    yy   = sub ? ~y : y;
    ci   = sub ? ~cin : cin;
    {co, sum} = {1'b0, x} + {1'b0, yy} + {{DW{1'b0}}, ci};
    lo   = {1'b0, x[HB:0]} + {1'b0, yy[HB:0]} + {{(HB+1){1'b0}}, ci};
    cout = sub ? ~co : co;
    hc   = sub ? ~lo[HB+1] : lo[HB+1];
    ovf  = (x[DW-1] == yy[DW-1]) && (sum[DW-1] != x[DW-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  output logic [DW-1:0] and_r,
  output logic [DW-1:0] or_r,
  output logic [DW-1:0] xor_r,
  output logic [DW-1:0] com_r
);
  always_comb begin
    and_r = x & y;
    or_r  = x | y;
    xor_r = x ^ y;
    com_r = ~x;
  end
endmodule

// File: rtl/alu8_flagmux.sv
module alu8_flagmux
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]       op,
  input  logic [DW-1:0]    ar_sum,
  input  logic             ar_c,
  input  logic             ar_h,
  input  logic             ar_v,
  input  logic [DW-1:0]    lg_and,
  input  logic [DW-1:0]    lg_or,
  input  logic [DW-1:0]    lg_xor,
  input  logic [DW-1:0]    lg_com,
  input  logic [NFLAG-1:0] fin,
  output logic [DW-1:0]    res,
  output logic [NFLAG-1:0] fout,
  output logic [NFLAG-1:0] mask
);
  localparam logic [NFLAG-1:0] M_ALL = '1;
  localparam logic [NFLAG-1:0] M_LOG = (1 << FS) | (1 << FV) | (1 << FN) | (1 << FZ);
  localparam logic [NFLAG-1:0] M_COM = M_LOG | (1 << FC);

  logic [NFLAG-1:0] nf;
  logic             sticky_z;

  always_comb begin
    res      = '0;
    mask     = '0;
    nf       = fin;
    sticky_z = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        res      = ar_sum;
        nf[FC]   = ar_c;
        nf[FH]   = ar_h;
        nf[FV]   = ar_v;
        mask     = M_ALL;
        sticky_z = (op == OP_SBC);
      end
      OP_AND, OP_TST: begin res = lg_and; nf[FV] = 1'b0; mask = M_LOG; end
      OP_OR:          begin res = lg_or;  nf[FV] = 1'b0; mask = M_LOG; end
      OP_XOR, OP_CLR: begin res = lg_xor; nf[FV] = 1'b0; mask = M_LOG; end
      OP_COM: begin
        res    = lg_com;
        nf[FC] = 1'b1;
        nf[FV] = 1'b0;
        mask   = M_COM;
      end
      OP_INC, OP_DEC: begin res = ar_sum; nf[FV] = ar_v; mask = M_LOG; end
      OP_SER: begin res = '1; mask = '0; end
      default: begin res = '0; mask = '0; end
    endcase
    nf[FN] = res[DW-1];
    nf[FZ] = (res == '0) && (!sticky_z || fin[FZ]);
    nf[FS] = nf[FN] ^ nf[FV];
    fout   = (nf & mask) | (fin & ~mask);
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8,
  parameter int HB = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_sel,
  input  logic [DW-1:0]    opd_a,
  input  logic [DW-1:0]    opd_b,
  input  logic [NFLAG-1:0] flags_in,
  output logic [DW-1:0]    res_q,
  output logic [NFLAG-1:0] flags_q,
  output logic [NFLAG-1:0] upd_q
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0]    ax, ay, ly;
  logic             acin, asub;
  logic [DW-1:0]    sum;
  logic             cout, hc, ovf;
  logic [DW-1:0]    r_and, r_or, r_xor, r_com;
  logic [DW-1:0]    res_d;
  logic [NFLAG-1:0] flags_d, upd_d;

  always_comb begin
    ax   = opd_a;
    ay   = opd_b;
    acin = 1'b0;
    asub = 1'b0;
    case (op_sel)
      OP_ADC: acin = flags_in[FC];
      OP_SUB: asub = 1'b1;
      OP_SBC: begin asub = 1'b1; acin = flags_in[FC]; end
      OP_NEG: begin ax = '0; ay = opd_a; asub = 1'b1; end
      OP_INC: ay = ONE;
      OP_DEC: begin ay = ONE; asub = 1'b1; end
      default: ;
    endcase
    ly = (op_sel == OP_TST || op_sel == OP_CLR) ? opd_a : opd_b;
  end

  alu8_addsub #(.DW(DW), .HB(HB)) u_arith (
    .x(ax), .y(ay), .cin(acin), .sub(asub),
    .sum(sum), .cout(cout), .hc(hc), .ovf(ovf)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .x(opd_a), .y(ly),
    .and_r(r_and), .or_r(r_or), .xor_r(r_xor), .com_r(r_com)
  );

  alu8_flagmux #(.DW(DW)) u_fmux (
    .op(op_sel), .ar_sum(sum), .ar_c(cout), .ar_h(hc), .ar_v(ovf),
    .lg_and(r_and), .lg_or(r_or), .lg_xor(r_xor), .lg_com(r_com),
    .fin(flags_in), .res(res_d), .fout(flags_d), .mask(upd_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
      upd_q   <= '0;
    end else begin
      res_q   <= res_d;
      flags_q <= flags_d;
      upd_q   <= upd_d;
    end
  end
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op_sel,
  input logic [DW-1:0]    opd_a,
  input logic [NFLAG-1:0] flags_in,
  input logic [DW-1:0]    res_q,
  input logic [NFLAG-1:0] flags_q,
  input logic [NFLAG-1:0] upd_q
);
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (res_q == '0 && flags_q == '0 && upd_q == '0));

  assert_passthru_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((flags_q & ~upd_q) == ($past(flags_in) & ~upd_q)));

  assert_sign_R10: assert property (@(posedge clk) disable iff (rst)
    upd_q[FS] |-> (flags_q[FS] == (flags_q[FN] ^ flags_q[FV])));

  assert_logic_keep_ch_R4: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR) |=>
      (flags_q[FC] == $past(flags_in[FC]) && flags_q[FH] == $past(flags_in[FH])
       && flags_q[FV] == 1'b0));

  assert_sbc_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SBC) |=> (flags_q[FZ] == ((res_q == '0) && $past(flags_in[FZ]))));

  assert_ser_R9: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_SER) |=> (res_q == '1 && upd_q == '0 && flags_q == $past(flags_in)));

  assert_com_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_COM) |=> (flags_q[FC] && res_q == ~$past(opd_a)));

  assert_clr_R8: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_CLR) |=> (res_q == '0 && flags_q[FZ] && !flags_q[FN]));
endmodule

bind alu8_core alu8_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .opd_a(opd_a), .flags_in(flags_in),
  .res_q(res_q), .flags_q(flags_q), .upd_q(upd_q)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_sel = '0;
  logic [7:0] opd_a = '0;
  logic [7:0] opd_b = '0;
  logic [5:0] flags_in = '0;
  logic [7:0] res_q;
  logic [5:0] flags_q;
  logic [5:0] upd_q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] res;
    logic [5:0] flg;
    logic [5:0] msk;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  alu8_core dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opd_a(opd_a), .opd_b(opd_b),
    .flags_in(flags_in), .res_q(res_q), .flags_q(flags_q), .upd_q(upd_q)
  );

  function automatic string tag_of(input int op);
    case (op)
      0, 1:    return "R1";
      2:       return "R2";
      3:       return "R3";
      4, 5, 6: return "R4";
      7:       return "R5";
      8:       return "R6";
      9, 10:   return "R7";
      11, 12:  return "R8";
      13:      return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic exp_t model(input int op, input int a, input int b, input logic [5:0] fi);
    exp_t e;
    int sa, sb2, c, t, sv, r;
    bit fc, fz, fn, fv, fh;
    logic [5:0] m, nf;
    sa = (a > 127) ? a - 256 : a;
    sb2 = (b > 127) ? b - 256 : b;
    c = (op == 1 || op == 3) ? int'(fi[0]) : 0;
    fc = 0; fh = 0; fv = 0; r = 0; m = 6'h00;
    case (op)
      0, 1: begin
        t = a + b + c; r = t % 256; fc = (t > 255);
        fh = (((a % 16) + (b % 16) + c) > 15);
        sv = sa + sb2 + c; fv = (sv > 127 || sv < -128); m = 6'h3F;
      end
      2, 3: begin
        t = a - b - c; r = (t + 256) % 256; fc = (t < 0);
        fh = (((a % 16) - (b % 16) - c) < 0);
        sv = sa - sb2 - c; fv = (sv > 127 || sv < -128); m = 6'h3F;
      end
      8: begin
        r = (256 - a) % 256; fc = (a != 0); fh = ((a % 16) != 0);
        fv = (a == 128); m = 6'h3F;
      end
      4: begin r = a & b; m = 6'h1E; end
      5: begin r = a | b; m = 6'h1E; end
      6: begin r = a ^ b; m = 6'h1E; end
      7: begin r = 255 - a; fc = 1; m = 6'h1F; end
      9: begin r = (a + 1) % 256; fv = (a == 127); m = 6'h1E; end
      10: begin r = (a + 255) % 256; fv = (a == 128); m = 6'h1E; end
      11: begin r = a; m = 6'h1E; end
      12: begin r = 0; m = 6'h1E; end
      13: begin r = 255; m = 6'h00; end
      default: begin r = 0; m = 6'h00; end
    endcase
    fn = (r > 127);
    fz = (r == 0);
    if (op == 3) fz = fz && fi[1];
    nf = {fh, fn ^ fv, fv, fn, fz, fc};
    e.res = r[7:0];
    e.msk = m;
    e.flg = (nf & m) | (fi & ~m);
    e.tag = tag_of(op);
    return e;
  endfunction

  task automatic drive(input int op, input int a, input int b, input logic [5:0] fi);
    @(negedge clk);
    op_sel = op[3:0];
    opd_a = a[7:0];
    opd_b = b[7:0];
    flags_in = fi;
    sb.push_back(model(op, a, b, fi));
  endtask

  // monitor: each result appears one clock after its inputs (R11)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (res_q !== e.res || flags_q !== e.flg || upd_q !== e.msk) begin
          bad++;
          $display("FAIL %s: res=%h flags=%b mask=%b expected res=%h flags=%b mask=%b",
                   e.tag, res_q, flags_q, upd_q, e.res, e.flg, e.msk);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op_sel = 4'd5; opd_a = 8'hAA; opd_b = 8'h55; flags_in = 6'h3F;
    repeat (3) @(posedge clk);
    #1;
    total++; // R11 reset state
    if (res_q !== 8'h00 || flags_q !== 6'h00 || upd_q !== 6'h00) begin
      bad++;
      $display("FAIL R11: res=%h flags=%b mask=%b expected all zero", res_q, flags_q, upd_q);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1 add boundaries
    drive(0, 8'h7F, 8'h01, 6'h00);
    drive(0, 8'hFF, 8'h01, 6'h00);
    drive(0, 8'h0F, 8'h01, 6'h00);
    drive(0, 8'h80, 8'h80, 6'h00);
    drive(1, 8'hFF, 8'h00, 6'h01);
    drive(1, 8'h10, 8'h20, 6'h01);
    // R2 subtract boundaries
    drive(2, 8'h80, 8'h01, 6'h00);
    drive(2, 8'h00, 8'h01, 6'h00);
    drive(2, 8'h10, 8'h01, 6'h00);
    drive(2, 8'h33, 8'h33, 6'h00);
    // R3 sticky zero
    drive(3, 8'h05, 8'h04, 6'h03);
    drive(3, 8'h05, 8'h04, 6'h01);
    drive(3, 8'h05, 8'h05, 6'h02);
    drive(3, 8'h06, 8'h05, 6'h02);
    // R4 logic with C and H preset
    drive(4, 8'hF0, 8'h0F, 6'h21);
    drive(5, 8'h80, 8'h01, 6'h29);
    drive(6, 8'hAA, 8'hAA, 6'h21);
    // R5, R6
    drive(7, 8'hFF, 0, 6'h00);
    drive(7, 8'h12, 0, 6'h08);
    drive(8, 8'h80, 0, 6'h00);
    drive(8, 8'h00, 0, 6'h3F);
    drive(8, 8'h01, 0, 6'h00);
    // R7
    drive(9, 8'h7F, 0, 6'h21);
    drive(9, 8'hFF, 0, 6'h00);
    drive(10, 8'h80, 0, 6'h21);
    drive(10, 8'h00, 0, 6'h00);
    // R8, R9, R11 reserved
    drive(11, 8'h80, 8'h00, 6'h09);
    drive(12, 8'h5A, 8'hFF, 6'h3F);
    drive(13, 8'h00, 8'h00, 6'h2B);
    drive(14, 8'h44, 8'h22, 6'h15);
    drive(15, 8'h44, 8'h22, 6'h2A);

    // R10 mixed codes, random operands and flags
    for (int i = 0; i < 600; i++) begin
      drive(i % 16, $urandom % 256, $urandom % 256, 6'($urandom));
    end

    @(negedge clk);
    op_sel = 4'd13;
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule